// File: doc/BRIEF.md
# Programmable Serial Frame Transfer Engine

This block is the master end of a synchronous serial link. It moves one data word per transfer: the word is shifted out MSB first on a transmit line, and a word of the same length is gathered from a receive line at the same time. The block generates the serial clock and a frame sync line itself. A set of configuration inputs shapes every transfer: which clock edges drive and sample data, the idle clock level, the active level of the frame, an idle lead-in, extra clocks before and after the data, the word length, where the frame starts and how long it lasts in half clock units, and the level the transmit line takes once the last bit has gone out.

A transfer starts with a one-cycle `start` pulse. At that cycle the configuration and the transmit word are checked and captured. If the settings break the frame timing rules, the request is refused and `err` is raised. Otherwise `busy` stays high for the whole transfer, and `done` pulses for one cycle together with the new right-justified `rx_word`. The serial clock runs at one half period per `HALF_DIV` system clocks.

Top module: `spp_engine`

## Requirements
- R1: While not busy, `sclk` sits at the idle level of the selected clock mode (low for modes 0 and 1, high for modes 2 and 3), and `frm` sits at its inactive level (low when `cfg_frm_hi`=1, high when it is 0).
- R2: An accepted start keeps `busy` high for exactly 2*(sdly+dstart+dsize+dstop)*HALF_DIV cycles. A one-cycle `done` follows as `busy` falls.
- R3: `sclk` stays idle during the start delay. It then gives one clock period for each dummy-start, data and dummy-stop period. The sample edge is the mid-period edge: rising in modes 0 and 3, falling in modes 1 and 2. There are dstart+dsize+dstop sample edges per transfer.
- R4: Data goes out MSB first and changes at the start of each period (the drive edge). `rxd` is sampled on the sample edge. With `rxd` tied to `txd`, `rx_word` equals the transmit word masked to its low dsize bits.
- R5: The frame becomes active fdly half periods after the transfer begins. This is fdly*HALF_DIV+1 cycles after `busy` rises, since the pins are registered. The frame may begin inside the data, after the MSB.
- R6: The frame stays active for 2*fwid*HALF_DIV cycles.
- R7: After the LSB (dummy stop) and after the transfer, `txd` is `tx_word[0]` when `cfg_tail_b0`=1 and 0 otherwise.
- R8: A start is refused, with `err` set and `busy` left low, when any of these holds: dsize outside 4..W, fwid outside 1..44, fdly above 88, fdly+2*fwid above the transfer length in half periods, or fdly+2*fwid below 2*sdly+2.
- R9: A start while busy is ignored. The configuration and transmit word are captured only at an accepted start.
- R10: `err` clears at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | transfer request pulse |
| cfg_mode | input | 2 | clock edge mode 0..3 |
| cfg_frm_hi | input | 1 | 1: frame active high, 0: active low |
| cfg_sdly | input | 3 | start delay, clock periods |
| cfg_dstart | input | 2 | dummy clocks before data |
| cfg_dsize | input | 6 | word length in bits |
| cfg_dstop | input | 2 | dummy clocks after data |
| cfg_fdly | input | 7 | frame delay, half periods |
| cfg_fwid | input | 6 | frame width, clock periods |
| cfg_tail_b0 | input | 1 | 1: hold bit 0 after LSB, 0: drive low |
| tx_word | input | W | word to send, right-justified |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle end-of-transfer pulse |
| err | output | 1 | last start refused for bad timing |
| rx_word | output | W | received word, right-justified |
| sclk | output | 1 | serial clock |
| frm | output | 1 | frame sync |
| txd | output | 1 | serial transmit data |
| rxd | input | 1 | serial receive data |

## Verification
The bench builds the engine with W=32 and HALF_DIV=3. An odd divider gives half periods of unequal phase relative to the system clock, and a 32-bit word allows both the longest legal transfer (90 half periods) and the largest frame delay (88). The serial receive line is looped back to transmit, so each of the four clock modes checks drive and sample edge placement end to end. Deliberately bad settings cover every refusal rule.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef struct packed {
    logic [1:0] mode;
    logic       frm_hi;
    logic [2:0] sdly;
    logic [1:0] dstart;
    logic [5:0] dsize;
    logic [1:0] dstop;
    logic [6:0] fdly;
    logic [5:0] fwid;
    logic       tail_b0;
  } cfg_t;

  // transfer length in half serial periods
  function automatic logic [7:0] half_total(input logic [2:0] sdly, input logic [1:0] dstart,
                                            input logic [5:0] dsize, input logic [1:0] dstop);
    logic [7:0] per;
    per = 8'(sdly) + 8'(dstart) + 8'(dsize) + 8'(dstop);
    return {per[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/spp_cfg_chk.sv
module spp_cfg_chk #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int MAX_FDLY = 88,
  parameter int MAX_FWID = 44
) (
  input  logic [2:0] sdly,
  input  logic [1:0] dstart,
  input  logic [5:0] dsize,
  input  logic [1:0] dstop,
  input  logic [6:0] fdly,
  input  logic [5:0] fwid,
  output logic       ok
);
  logic [7:0] hl, fend, fmin;

  always_comb begin
    hl   = spp_pkg::half_total(sdly, dstart, dsize, dstop);
    fend = 8'(fdly) + 8'({fwid, 1'b0});
    fmin = 8'({sdly, 1'b0}) + 8'd2;
    ok   = (dsize >= 6'(MIN_BITS)) && (dsize <= 6'(MAX_BITS)) &&
           (fwid != 6'd0) && (fwid <= 6'(MAX_FWID)) &&
           (fdly <= 7'(MAX_FDLY)) && (fend <= hl) && (fend >= fmin);
  end
endmodule

// File: rtl/spp_seq.sv
module spp_seq #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] half_len,
  output logic       busy,
  output logic       done,
  output logic [7:0] h,
  output logic       ht,
  output logic       fin
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div;

  assign ht  = busy && (div == DIV_LAST);
  assign fin = ht && (h == half_len - 8'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      h    <= '0;
      div  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        h    <= '0;
        div  <= '0;
      end else if (busy) begin
        if (div == DIV_LAST) begin
          div <= '0;
          if (fin) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            h <= h + 8'd1;
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end

  // R2
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  h_in_range_chk: assert property (@(posedge clk) disable iff (rst) busy |-> (h < half_len));
  // R2
  fresh_count_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> (h == 8'd0));
endmodule

// File: rtl/spp_pins.sv
module spp_pins #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         busy,
  input  logic [7:0]   h,
  input  logic [1:0]   mode,
  input  logic         frm_hi,
  input  logic [2:0]   sdly,
  input  logic [1:0]   dstart,
  input  logic [5:0]   dsize,
  input  logic [6:0]   fdly,
  input  logic [5:0]   fwid,
  input  logic         tail_b0,
  input  logic [W-1:0] word,
  input  logic         live_idle_hi,
  input  logic         live_frm_hi,
  output logic         sclk,
  output logic         frm,
  output logic         txd,
  output logic         smp
);
  localparam int IW = $clog2(W);

  logic [6:0]    p, d_start, d_end;
  logic [IW-1:0] idx;
  logic [7:0]    fend;
  logic          in_data, tail, fh, sclk_n, frm_n, txd_n;

  always_comb begin
    p       = h[7:1];
    d_start = 7'(sdly) + 7'(dstart);
    d_end   = d_start + 7'(dsize);
    in_data = (p >= d_start) && (p < d_end);
    idx     = IW'(d_end - 7'd1 - p);
    tail    = tail_b0 & word[0];
    fend    = 8'(fdly) + 8'({fwid, 1'b0});
    fh      = mode[0] ^ mode[1];
    smp     = busy && in_data && !h[0];
    if (!busy) begin
      sclk_n = live_idle_hi;
      frm_n  = !live_frm_hi;
      txd_n  = tail;
    end else begin
      if (p < 7'(sdly)) sclk_n = mode[1];
      else              sclk_n = h[0] ? !fh : fh;
      frm_n = ((h >= 8'(fdly)) && (h < fend)) ? frm_hi : !frm_hi;
      if (in_data)         txd_n = word[idx];
      else if (p >= d_end) txd_n = tail;
      else                 txd_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      frm  <= 1'b0;
      txd  <= 1'b0;
    end else begin
      sclk <= sclk_n;
      frm  <= frm_n;
      txd  <= txd_n;
    end
  end

  // R3
  sclk_idle_in_lead_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && ($past(h[7:1]) < 7'(sdly))) |-> (sclk == mode[1]));
endmodule

// File: rtl/spp_rxsr.sv
module spp_rxsr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         rxd,
  input  logic         fin,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rx_word <= '0;
    end else begin
      if (clr)        sr <= '0;
      else if (shift) sr <= {sr[W-2:0], rxd};
      if (fin) rx_word <= sr;
    end
  end

  // R4
  rx_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fin) |-> $stable(rx_word));
endmodule

// File: rtl/spp_engine.sv
module spp_engine #(
  parameter int W        = 32,
  parameter int HALF_DIV = 2,
  parameter int MIN_BITS = 4,
  parameter int MAX_FDLY = 88,
  parameter int MAX_FWID = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   cfg_mode,
  input  logic         cfg_frm_hi,
  input  logic [2:0]   cfg_sdly,
  input  logic [1:0]   cfg_dstart,
  input  logic [5:0]   cfg_dsize,
  input  logic [1:0]   cfg_dstop,
  input  logic [6:0]   cfg_fdly,
  input  logic [5:0]   cfg_fwid,
  input  logic         cfg_tail_b0,
  input  logic [W-1:0] tx_word,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] rx_word,
  output logic         sclk,
  output logic         frm,
  output logic         txd,
  input  logic         rxd
);
  spp_pkg::cfg_t cq;
  logic [W-1:0]  wq;
  logic          ok, go, ht, fin, smp;
  logic [7:0]    h, half_len;

  assign go       = start && !busy && ok;
  assign half_len = spp_pkg::half_total(cq.sdly, cq.dstart, cq.dsize, cq.dstop);

  spp_cfg_chk #(.MAX_BITS(W), .MIN_BITS(MIN_BITS), .MAX_FDLY(MAX_FDLY), .MAX_FWID(MAX_FWID)) chk_i (
    .sdly(cfg_sdly), .dstart(cfg_dstart), .dsize(cfg_dsize), .dstop(cfg_dstop),
    .fdly(cfg_fdly), .fwid(cfg_fwid), .ok(ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      cq  <= '0;
      wq  <= '0;
      err <= 1'b0;
    end else if (go) begin
      cq  <= '{mode: cfg_mode, frm_hi: cfg_frm_hi, sdly: cfg_sdly, dstart: cfg_dstart,
               dsize: cfg_dsize, dstop: cfg_dstop, fdly: cfg_fdly, fwid: cfg_fwid,
               tail_b0: cfg_tail_b0};
      wq  <= tx_word;
      err <= 1'b0;
    end else if (start && !busy) begin
      err <= 1'b1;
    end
  end

  spp_seq #(.HALF_DIV(HALF_DIV)) seq_i (
    .clk(clk), .rst(rst), .go(go), .half_len(half_len), .busy(busy), .done(done),
    .h(h), .ht(ht), .fin(fin));

  spp_pins #(.W(W)) pins_i (
    .clk(clk), .rst(rst), .busy(busy), .h(h), .mode(cq.mode), .frm_hi(cq.frm_hi),
    .sdly(cq.sdly), .dstart(cq.dstart), .dsize(cq.dsize), .fdly(cq.fdly), .fwid(cq.fwid),
    .tail_b0(cq.tail_b0), .word(wq), .live_idle_hi(cfg_mode[1]), .live_frm_hi(cfg_frm_hi),
    .sclk(sclk), .frm(frm), .txd(txd), .smp(smp));

  spp_rxsr #(.W(W)) rx_i (
    .clk(clk), .rst(rst), .clr(go), .shift(ht && smp), .rxd(rxd), .fin(fin), .rx_word(rx_word));

  // R8
  refuse_bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !ok) |=> (!busy && err));
  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (rst) err |-> !busy);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
endmodule

// File: tb/spp_engine_tb.sv
module spp_engine_tb_top;
  localparam int W  = 32;
  localparam int HD = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_frm_hi = 1'b1, cfg_tail_b0 = 1'b0;
  logic [2:0] cfg_sdly = 3'd0;
  logic [1:0] cfg_dstart = 2'd0, cfg_dstop = 2'd0;
  logic [5:0] cfg_dsize = 6'd8, cfg_fwid = 6'd1;
  logic [6:0] cfg_fdly = 7'd0;
  logic [W-1:0] tx_word = '0;
  logic busy, done, err, sclk, frm, txd;
  logic [W-1:0] rx_word;

  int total = 0, bad = 0, done_cnt = 0, cyc = 0;
  bit finished = 0;
  logic [W-1:0] expq[$];

  always #10 clk = ~clk;

  spp_engine #(.W(W), .HALF_DIV(HD)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_frm_hi(cfg_frm_hi),
    .cfg_sdly(cfg_sdly), .cfg_dstart(cfg_dstart), .cfg_dsize(cfg_dsize), .cfg_dstop(cfg_dstop),
    .cfg_fdly(cfg_fdly), .cfg_fwid(cfg_fwid), .cfg_tail_b0(cfg_tail_b0), .tx_word(tx_word),
    .busy(busy), .done(done), .err(err), .rx_word(rx_word), .sclk(sclk), .frm(frm),
    .txd(txd), .rxd(txd));

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected words as done pulses appear (R4)
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (expq.size() == 0) chk(0, "R9", "unexpected done", rx_word, 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(rx_word == e, "R4", "rx word", rx_word, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic set_cfg(input int mode, input bit hi, input int sd, input int dst, input int ds,
                         input int dsp, input int fd, input int fw, input bit tb0);
    cfg_mode = 2'(mode); cfg_frm_hi = hi; cfg_sdly = 3'(sd); cfg_dstart = 2'(dst);
    cfg_dsize = 6'(ds); cfg_dstop = 2'(dsp); cfg_fdly = 7'(fd); cfg_fwid = 6'(fw);
    cfg_tail_b0 = tb0;
  endtask

  task automatic xfer(input int mode, input bit hi, input int sd, input int dst, input int ds,
                      input int dsp, input int fd, input int fw, input bit tb0,
                      input logic [W-1:0] word, input bit poke);
    int bn = 0, fdc = 0, fac = 0, se = 0, d0;
    bit prev, fall_smp, last;
    logic [W-1:0] mask;
    mask = (ds >= 32) ? '1 : W'((64'd1 << ds) - 1);
    @(negedge clk);
    set_cfg(mode, hi, sd, dst, ds, dsp, fd, fw, tb0);
    tx_word = word;
    start = 1'b1;
    expq.push_back(word & mask);
    d0 = done_cnt;
    fall_smp = (mode == 1 || mode == 2);
    @(negedge clk);
    start = 1'b0;
    prev = sclk;
    last = 0;
    while (!last) begin
      if (!busy) last = 1;
      if (busy) bn++;
      if (frm == hi) fac++;
      else if (fac == 0) fdc++;
      if (fall_smp ? (prev && !sclk) : (!prev && sclk)) se++;
      prev = sclk;
      if (poke && bn == 10) begin start = 1'b1; tx_word = ~word; end
      else start = 1'b0;
      if (!last) @(negedge clk);
    end
    start = 1'b0;
    chk(bn == 2*(sd+dst+ds+dsp)*HD, "R2", "busy length", bn, 2*(sd+dst+ds+dsp)*HD);
    chk(se == dst+ds+dsp, "R3", "sample edges", se, dst+ds+dsp);
    chk(fdc == fd*HD+1, "R5", "frame delay", fdc, fd*HD+1);
    chk(fac == 2*fw*HD, "R6", "frame width", fac, 2*fw*HD);
    @(negedge clk);
    chk(txd == (tb0 & word[0]), "R7", "tail level", txd, tb0 & word[0]);
    chk(sclk == (mode >= 2), "R1", "sclk idle", sclk, mode >= 2);
    chk(frm == !hi, "R1", "frame idle", frm, !hi);
    chk(done_cnt == d0 + 1 && expq.size() == 0, "R9", "one done per transfer", done_cnt, d0 + 1);
  endtask

  task automatic refuse(input int sd, input int dst, input int ds, input int dsp,
                        input int fd, input int fw, input string what);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    set_cfg(0, 1, sd, dst, ds, dsp, fd, fw, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy, "R8", what, {err, busy}, 2'b10);
    repeat (4) @(negedge clk);
    chk(!busy && done_cnt == d0, "R8", {what, " no transfer"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err, "R2", "reset idle flags", {busy, done, err}, 0);
    chk(sclk == 1'b0 && frm == 1'b0, "R1", "reset pins mode0 active-high", {sclk, frm}, 0);
    set_cfg(2, 0, 0, 0, 8, 0, 0, 4, 0);
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1 && frm == 1'b1, "R1", "idle mode2 active-low", {sclk, frm}, 2'b11);

    xfer(0, 1, 1, 1, 8, 1, 2, 1, 0, 32'h0000_00A5, 0);
    xfer(1, 0, 0, 0, 4, 0, 0, 4, 1, 32'hFFFF_FFF7, 0);
    xfer(2, 1, 7, 3, 32, 3, 88, 1, 1, 32'hDEAD_BEEF, 0);
    xfer(3, 0, 2, 2, 13, 2, 10, 14, 0, 32'h0000_1ABC, 0);
    xfer(0, 1, 1, 1, 8, 1, 2, 1, 1, 32'h0000_003C, 1);

    refuse(0, 0, 3, 0, 0, 2, "dsize below 4");
    refuse(0, 0, 33, 0, 0, 2, "dsize above W");
    refuse(0, 0, 8, 0, 0, 0, "zero frame width");
    refuse(1, 1, 8, 1, 2, 20, "frame past end");
    refuse(5, 0, 8, 0, 0, 1, "frame ends too early");
    refuse(7, 3, 32, 3, 89, 1, "frame delay above 88");

    xfer(1, 1, 0, 1, 16, 2, 3, 4, 0, 32'h0000_C35A, 0);
    chk(err == 1'b0, "R10", "err cleared by accepted start", err, 0);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule